// File: doc/BRIEF.md
# Key-Tunable Direct Digital Sine Synthesizer

This block produces a digital sine wave for an external parallel DAC. Every system clock cycle a 20-bit phase accumulator grows by a frequency word. The upper 10 accumulator bits, plus a phase word, form a registered address. That address selects a 10-bit sample from a 1024-entry sine table, and the sample goes to the DAC data port through one more register. The DAC conversion clock is the system clock divided by two. With a 50 MHz clock, each step of the frequency word moves the output by about 47.68 Hz. The usable range is about 47.68 Hz to about 48.8 kHz.

Three single-cycle strobes, already debounced, tune the generator. The first raises the frequency word by one and the second lowers it by one. The third advances the phase word by a quarter turn. A phase strobe also clears the accumulator and the address register on the same clock edge. The new phase therefore counts from a clean origin and does not depend on how long the generator had been running. The DAC port has no handshake: a new sample appears every system clock, and the converter cannot hold it back. Any strobe held high for several cycles acts once per cycle.

Top module: `dds_sine_gen`

## Requirements
- R1: While reset is low, and right after it is released, `dac_data` is 512, `dac_clk` is 0, the frequency word is 105 and the phase word is 0.
- R2: The accumulator adds the frequency word every clock, modulo 2^20. The output period, measured between rising mid-scale crossings, is 2^20/F clocks, or an adjacent integer when F does not divide 2^20.
- R3: The address register takes accumulator bits 19..10 plus the phase word, modulo 1024. `dac_data` after edge k of a fresh run is the table entry at address ((((k-2)·F) mod 2^20) >> 10) + P. After edge 1 it is entry 0.
- R4: Table entry i is offset binary, equal to 512 + round(511·sin(2πi/1024)). So entry 0 is 512, entry 256 is 1023, entry 512 is 512 and entry 768 is 1.
- R5: A `freq_up` strobe raises the frequency word by 1 and stops at 1024.
- R6: A `freq_dn` strobe lowers the frequency word by 1 and stops at 1.
- R7: When `freq_up` and `freq_dn` are high in the same cycle, the frequency word does not change.
- R8: A `phase_step` strobe adds 256 (90 degrees) to the phase word, modulo 1024. Four strobes give back the original phase.
- R9: On the edge that takes a `phase_step` strobe, the accumulator and the address register go to zero. From then on, `dac_data` follows the R3 sequence with the new phase word, counting the edges from that strobe edge.
- R10: `dac_clk` toggles on every system clock edge, so its frequency is half the system clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| freq_up | input | 1 | One-cycle strobe: frequency word +1 |
| freq_dn | input | 1 | One-cycle strobe: frequency word -1 |
| phase_step | input | 1 | One-cycle strobe: phase +90 degrees, clears accumulator |
| dac_clk | output | 1 | DAC conversion clock, system clock divided by two |
| dac_data | output | 10 | Offset-binary sine sample |

## Verification
The phase word has no port of its own, so a wrong phase word only shows as a shifted sample sequence. It shows two edges after the next phase strobe, where the samples no longer match a fresh run taken 256 addresses earlier.

A frequency word off by one, or one that wraps instead of stopping, changes the spacing between mid-scale crossings. This shows within two output periods, measured at frequency words that are powers of two, where the period is exact. If the accumulator is not fully cleared, the samples after a strobe that follows a long run already disagree with the predicted sequence at the second sample. A wrong table entry shows as soon as a full-speed sweep with F = 1024 walks the addresses one by one.

// File: rtl/dds_pkg.sv
package dds_pkg;

  // pi/2 in Q2.30 fixed point
  localparam longint HALF_PI_Q30 = 64'sd1686629713;

  // Offset-binary sine sample for table index idx, table of 2**aw entries,
  // sample width sw. Quarter-wave folding with an odd Taylor series.
  function automatic int sine_code(int idx, int aw, int sw);
    longint x, x2, term, sum, mag;
    int quarter, q, j, amp, mid;
    quarter = 1 << (aw - 2);
    q       = (idx >> (aw - 2)) & 3;
    j       = idx & (quarter - 1);
    if (q[0]) j = quarter - j;
    amp  = (1 << (sw - 1)) - 1;
    mid  = 1 << (sw - 1);
    x    = (longint'(j) * HALF_PI_Q30) >>> (aw - 2);
    x2   = (x * x) >>> 30;
    term = x;
    sum  = x;
    for (int n = 1; n <= 4; n++) begin
      term = -(((term * x2) >>> 30) / longint'((2 * n) * (2 * n + 1)));
      sum  = sum + term;
    end
    mag = (sum * longint'(amp) + (64'sd1 <<< 29)) >>> 30;
    return q[1] ? (mid - int'(mag)) : (mid + int'(mag));
  endfunction

endpackage

// File: rtl/dds_tune_ctrl.sv
module dds_tune_ctrl #(
  parameter int FREQ_W    = 11,
  parameter int PH_W      = 10,
  parameter int FREQ_INIT = 105
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_i,
  input  logic              dn_i,
  input  logic              ph_i,
  output logic [FREQ_W-1:0] fword_o,
  output logic [PH_W-1:0]   pword_o,
  output logic              clr_o
);
  localparam logic [FREQ_W-1:0] F_MAX  = FREQ_W'(1 << (FREQ_W - 1));
  localparam logic [FREQ_W-1:0] F_MIN  = FREQ_W'(1);
  localparam logic [FREQ_W-1:0] F_INIT = FREQ_W'(FREQ_INIT);
  localparam logic [PH_W-1:0]   P_STEP = PH_W'(1 << (PH_W - 2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fword_o <= F_INIT;
      pword_o <= '0;
    end else begin
      if (up_i && !dn_i && fword_o != F_MAX)
        fword_o <= fword_o + F_MIN;
      else if (dn_i && !up_i && fword_o != F_MIN)
        fword_o <= fword_o - F_MIN;
      if (ph_i)
        pword_o <= pword_o + P_STEP;
    end
  end

  assign clr_o = ph_i;

  AST_FREQ_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (fword_o >= F_MIN) && (fword_o <= F_MAX)); // R5
  AST_FREQ_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (up_i && !dn_i && fword_o != F_MAX) |=> (fword_o == $past(fword_o) + F_MIN)); // R5
  AST_FREQ_DN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_i && !up_i && fword_o != F_MIN) |=> (fword_o == $past(fword_o) - F_MIN)); // R6
  AST_FREQ_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (up_i && dn_i) |=> $stable(fword_o)); // R7
  AST_PHASE_QUARTER: assert property (@(posedge clk) disable iff (!rst_n)
    ph_i |=> (pword_o == $past(pword_o) + P_STEP)); // R8

endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int ACC_W  = 20,
  parameter int ADDR_W = 10,
  parameter int FREQ_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic [FREQ_W-1:0] fword_i,
  input  logic [ADDR_W-1:0] pword_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ACC_W-1:0] acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      addr_o <= '0;
    end else if (clr_i) begin
      acc_q  <= '0;
      addr_o <= '0;
    end else begin
      acc_q  <= acc_q + ACC_W'(fword_i);
      addr_o <= acc_q[ACC_W-1 -: ADDR_W] + pword_i;
    end
  end

  AST_CLEAR_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (acc_q == '0) && (addr_o == '0)); // R9
  AST_ACC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> (acc_q == $past(acc_q) + ACC_W'($past(fword_i)))); // R2

endmodule

// File: rtl/dds_sine_rom.sv
module dds_sine_rom #(
  parameter int ADDR_W = 10,
  parameter int SAMP_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [SAMP_W-1:0] data_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [SAMP_W-1:0] MID = SAMP_W'(1 << (SAMP_W - 1));

  logic [SAMP_W-1:0] lut [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    localparam int VAL = dds_pkg::sine_code(g, ADDR_W, SAMP_W);
    assign lut[g] = VAL[SAMP_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_o <= MID;
    else        data_o <= lut[addr_i];
  end

  AST_SAMPLE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    data_o != '0); // R4

endmodule

// File: rtl/dds_sine_gen.sv
module dds_sine_gen #(
  parameter int ACC_W     = 20,
  parameter int ADDR_W    = 10,
  parameter int SAMP_W    = 10,
  parameter int FREQ_INIT = 105
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              freq_up,
  input  logic              freq_dn,
  input  logic              phase_step,
  output logic              dac_clk,
  output logic [SAMP_W-1:0] dac_data
);
  localparam int FREQ_W = ADDR_W + 1;

  logic [FREQ_W-1:0] fword;
  logic [ADDR_W-1:0] pword;
  logic [ADDR_W-1:0] addr;
  logic              clr;

  dds_tune_ctrl #(
    .FREQ_W(FREQ_W), .PH_W(ADDR_W), .FREQ_INIT(FREQ_INIT)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .up_i(freq_up), .dn_i(freq_dn), .ph_i(phase_step),
    .fword_o(fword), .pword_o(pword), .clr_o(clr)
  );

  dds_phase_acc #(
    .ACC_W(ACC_W), .ADDR_W(ADDR_W), .FREQ_W(FREQ_W)
  ) u_acc (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .fword_i(fword), .pword_i(pword),
    .addr_o(addr)
  );

  dds_sine_rom #(
    .ADDR_W(ADDR_W), .SAMP_W(SAMP_W)
  ) u_rom (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .data_o(dac_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dac_clk <= 1'b0;
    else        dac_clk <= ~dac_clk;
  end

  AST_DACCLK_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (dac_clk != $past(dac_clk))); // R10

endmodule

// File: tb/dds_sine_gen_test.sv
module dds_sine_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       freq_up = 1'b0;
  logic       freq_dn = 1'b0;
  logic       phase_step = 1'b0;
  logic       dac_clk;
  logic [9:0] dac_data;

  int total = 0;
  int bad = 0;
  int cur_f = 105;
  int cur_p = 0;
  bit done = 0;
  int cap_a [0:1400];
  int cap_b [0:1100];

  // {frequency word, expected period in clocks, allowed extra clocks}
  localparam int VEC [6][3] = '{
    '{1024, 1024, 0}, '{512, 2048, 0}, '{256, 4096, 0},
    '{128, 8192, 0},  '{105, 9986, 1}, '{1000, 1048, 1}
  };

  dds_sine_gen uut (
    .clk(clk), .rst_n(rst_n), .freq_up(freq_up), .freq_dn(freq_dn),
    .phase_step(phase_step), .dac_clk(dac_clk), .dac_data(dac_data)
  );

  always #5 clk = ~clk;

  function automatic int sref(int i);
    real v;
    v = 512.0 + 511.0 * $sin(2.0 * 3.14159265358979 * real'(i) / 1024.0);
    return int'(v);
  endfunction

  function automatic int exp_data(int k, int f, int p);
    if (k <= 1) return 512;
    return sref(((((k - 2) * f) & 32'hFFFFF) >> 10) + p & 1023);
  endfunction

  task automatic chk(string req, int act, int exp, int tol);
    total++;
    if (act < exp || act > exp + tol) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Press the frequency keys for n cycles, with a saturating bench model.
  task automatic press(bit up, bit dn, int n);
    @(negedge clk);
    freq_up = up; freq_dn = dn;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (up && !dn && cur_f < 1024) cur_f++;
      else if (dn && !up && cur_f > 1) cur_f--;
    end
    freq_up = 1'b0; freq_dn = 1'b0;
  endtask

  task automatic set_freq(int target);
    if (target > cur_f) press(1'b1, 1'b0, target - cur_f);
    else if (target < cur_f) press(1'b0, 1'b1, cur_f - target);
  endtask

  // Strobes the phase key n times; returns at the negedge after the last strobe edge.
  task automatic phase_press(int n);
    @(negedge clk);
    phase_step = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cur_p = (cur_p + 256) % 1024;
    end
    phase_step = 1'b0;
  endtask

  // Compares n samples against the predicted sequence; returns the mismatch count.
  task automatic window(int n, int f, int p, output int miss);
    miss = 0;
    for (int k = 1; k <= n; k++) begin
      int e;
      @(negedge clk);
      e = exp_data(k, f, p);
      if (int'(dac_data) < e - 1 || int'(dac_data) > e + 1) begin
        if (miss == 0) $display("  sample k=%0d got=%0d want=%0d", k, dac_data, e);
        miss++;
      end
    end
  endtask

  task automatic measure(output int per);
    int prev, cur, n;
    prev = int'(dac_data);
    cur = prev;
    n = 0;
    per = -1;
    while (n < 40000) begin
      @(negedge clk); n++;
      cur = int'(dac_data);
      if (prev < 512 && cur >= 512) break;
      prev = cur;
    end
    per = 0;
    prev = cur;
    while (per < 40000) begin
      @(negedge clk); per++;
      cur = int'(dac_data);
      if (prev < 512 && cur >= 512) break;
      prev = cur;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R2 actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int miss, per, same;
    // Reset state: R1, R10
    repeat (3) @(negedge clk);
    chk("R1 reset dac_data", int'(dac_data), 512, 0);
    chk("R10 reset dac_clk", int'(dac_clk), 0, 0);
    rst_n = 1'b1;
    window(60, 105, 0, miss);
    chk("R1 R3 sequence after reset F=105 P=0", miss, 0, 0);

    // R10: toggles every edge
    miss = 0;
    for (int i = 0; i < 8; i++) begin
      logic prev_c;
      prev_c = dac_clk;
      @(negedge clk);
      if (dac_clk == prev_c) miss++;
    end
    chk("R10 dac_clk toggles every edge", miss, 0, 0);

    // Vector table: R2 periods
    foreach (VEC[i]) begin
      set_freq(VEC[i][0]);
      measure(per);
      chk("R2 output period", per, VEC[i][1], VEC[i][2]);
    end

    // R8 wrap and R4 table via full-speed sweep at F=1024
    set_freq(1024);
    phase_press(4);
    chk("R8 four quarter steps wrap", cur_p, 0, 0);
    for (int k = 1; k <= 1400; k++) begin
      @(negedge clk);
      cap_a[k] = int'(dac_data);
    end
    chk("R4 entry 0", cap_a[2], 512, 0);
    chk("R4 entry 256", cap_a[258], 1023, 0);
    chk("R4 entry 512", cap_a[514], 512, 0);
    chk("R4 entry 768", cap_a[770], 1, 0);
    miss = 0;
    for (int k = 1; k <= 1400; k++) begin
      int e;
      e = exp_data(k, 1024, 0);
      if (cap_a[k] < e - 1 || cap_a[k] > e + 1) miss++;
    end
    chk("R4 R8 sweep matches sine after phase wrap", miss, 0, 0);

    // R9: one quarter step shifts the sequence by exactly 256 addresses
    phase_press(1);
    for (int k = 1; k <= 1100; k++) begin
      @(negedge clk);
      cap_b[k] = int'(dac_data);
    end
    same = 0;
    for (int k = 2; k <= 1100; k++) if (cap_b[k] != cap_a[k + 256]) same++;
    chk("R9 R8 quarter step shifts by 256 addresses", same, 0, 0);

    // R9: absolute phase after a long, uneven accumulation
    set_freq(105);
    repeat (5003) @(negedge clk);
    phase_press(1);
    window(400, 105, cur_p, miss);
    chk("R9 absolute phase after long run P=512", miss, 0, 0);

    // R5: saturation at the top
    press(1'b1, 1'b0, 1500);
    press(1'b0, 1'b1, 512);
    measure(per);
    chk("R5 saturate at 1024 then down 512", per, 2048, 0);

    // R6: saturation at the bottom
    press(1'b0, 1'b1, 1000);
    press(1'b1, 1'b0, 255);
    measure(per);
    chk("R6 saturate at 1 then up 255", per, 4096, 0);

    // R7: both keys together change nothing
    press(1'b1, 1'b1, 300);
    measure(per);
    chk("R7 both keys leave frequency", per, 4096, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule